// File: doc/BRIEF.md
# Power-Management Event and Timer Unit

This block holds the event side of a power-management register set: a free-running tick counter read back as a timer, a 16-bit event status register, a 16-bit event enable register and a 16-bit control register. Software reaches all four through a small register port with a two-bit address. Status bits are cleared by writing ones. A level interrupt line is raised while any enabled event is pending.

The counter advances one step on each clock where `tick_en` is high. The timer-overflow status is set when the count reaches a stored overflow point. The first overflow point is 2^OVF_SHIFT. When software clears a pending overflow status, the overflow point moves to the next multiple of 2^OVF_SHIFT above the count at that moment. As a result, the flag fires on each transition of count bit OVF_SHIFT, as long as software acknowledges it.

A power-button event sets its status bit only when its enable is set. A control write with the go bit set starts a sleep command. Type 0 requests power-off. Type 1 fakes a wake: it sets the resume and power-button status bits and requests a reset.

Top module: `pm_evt_unit`

## Requirements
- R1: After reset, reads at every address return 0, `sci`, `off_req` and `rst_req` are low, the count is 0 and the first overflow point is 2^OVF_SHIFT. The addresses are 0 for status, 1 for enable, 2 for control and 3 for timer.
- R2: On each clock with `tick_en` high, the count increases by one. A read at address 3 returns the low TMR_W bits of the count, zero-extended. Writes to address 3 have no effect.
- R3: Status bit 0 (timer overflow) becomes 1 on the clock after the count is at or above the overflow point.
- R4: A status write with data bit 0 set, while status bit 0 is 1, moves the overflow point to the next multiple of 2^OVF_SHIFT strictly above the count in that cycle. No overflow is flagged in that cycle. If the write comes while status bit 0 is 0, the overflow point is left alone.
- R5: A status write clears each status bit whose data bit is 1 and leaves the others unchanged. An event that sets a bit in the same cycle wins over the clear.
- R6: The enable register stores only bit 0 (overflow), bit 5 (global), bit 8 (power button) and bit 10 (clock alarm). All other bits read 0.
- R7: A high `pwrbtn_evt` sets status bit 8 on the next clock only when enable bit 8 is 1. Otherwise the event is ignored.
- R8: `sci` is high exactly when some status bit and the same enable bit are both 1.
- R9: A control write stores every data bit except bit 13 (go), which always reads 0. Bits 12:10 hold the sleep type.
- R10: A control write with bit 13 set and type 0 drives `off_req` high for the single following cycle.
- R11: A control write with bit 13 set and type 1 sets status bits 15 (resume) and 8 on the next clock and drives `rst_req` high for that cycle. Other types, or bit 13 clear, raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advance the tick counter this cycle |
| pwrbtn_evt | input | 1 | Power-button event, one cycle per press |
| reg_addr | input | 2 | Register select: 0 status, 1 enable, 2 control, 3 timer |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | RD_W | Read data for `reg_addr`, combinational |
| sci | output | 1 | Level interrupt for pending enabled events |
| off_req | output | 1 | One-cycle power-off request |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The hardest case to reach is the rearm boundary: clearing the overflow flag when the count sits one below a multiple of 2^OVF_SHIFT. The new overflow point then equals the very next count, so the flag must come back on after only one tick. The bench shrinks OVF_SHIFT and uses its own model count to walk the counter to that value with the flag still pending. It then stops ticking, issues the clear, and lets exactly one tick through. Same-cycle races between a clear and a setting event are driven on purpose in the same way.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

  typedef enum logic [1:0] {
    REG_STS = 2'd0,
    REG_EN  = 2'd1,
    REG_CTL = 2'd2,
    REG_TMR = 2'd3
  } pm_reg_e;

  localparam int unsigned BIT_OVF    = 0;
  localparam int unsigned BIT_GLB    = 5;
  localparam int unsigned BIT_PWR    = 8;
  localparam int unsigned BIT_ALM    = 10;
  localparam int unsigned BIT_RESUME = 15;

  localparam int unsigned CTL_GO      = 13;
  localparam int unsigned CTL_TYPE_LO = 10;
  localparam int unsigned CTL_TYPE_W  = 3;

  localparam logic [2:0] SLP_OFF  = 3'd0;
  localparam logic [2:0] SLP_WAKE = 3'd1;

  localparam logic [15:0] EN_MASK = (16'h1 << BIT_OVF) | (16'h1 << BIT_GLB)
                                  | (16'h1 << BIT_PWR) | (16'h1 << BIT_ALM);

endpackage

// File: rtl/pm_tick_timer.sv
module pm_tick_timer #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned OVF_SHIFT = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             rearm,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_hit
);

  localparam logic [CNT_W-1:0] STEP = CNT_W'(1) << OVF_SHIFT;

  logic [CNT_W-1:0] pt_q;

  // Next overflow point: count plus one period, rounded down to a period.
  function automatic logic [CNT_W-1:0] next_point(input logic [CNT_W-1:0] c);
    logic [CNT_W-1:0] s;
    s = c + STEP;
    return s & ~(STEP - CNT_W'(1));
  endfunction

  assign ovf_hit = (cnt_q >= pt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pt_q  <= STEP;
    end else begin
      if (tick_en) cnt_q <= cnt_q + CNT_W'(1);
      if (rearm)   pt_q  <= next_point(cnt_q);
    end
  end

  AST_REARM_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> (pt_q > $past(cnt_q))); // R4

  AST_POINT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> ((pt_q & (STEP - CNT_W'(1))) == '0)); // R4

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/pm_status_regs.sv
module pm_status_regs
  import pm_evt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_sts,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  input  logic        ovf_hit,
  input  logic        pwrbtn_evt,
  input  logic        resume_set,
  output logic [15:0] sts_q,
  output logic [15:0] en_q,
  output logic        rearm,
  output logic        sci
);

  logic [15:0] clr_vec;
  logic [15:0] set_vec;
  logic        pwr_set;

  assign clr_vec = wr_sts ? wdata : 16'h0;
  assign rearm   = wr_sts & wdata[BIT_OVF] & sts_q[BIT_OVF];
  assign pwr_set = pwrbtn_evt & en_q[BIT_PWR];

  always_comb begin
    set_vec             = '0;
    set_vec[BIT_OVF]    = ovf_hit & ~rearm;
    set_vec[BIT_PWR]    = pwr_set | resume_set;
    set_vec[BIT_RESUME] = resume_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= (sts_q & ~clr_vec) | set_vec;
      if (wr_en) en_q <= wdata & EN_MASK;
    end
  end

  assign sci = |(sts_q & en_q);

  AST_OVF_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[BIT_OVF]) |-> $past(ovf_hit)); // R3

  AST_W1C_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && wdata[BIT_PWR] && !pwrbtn_evt && !resume_set) |=> !sts_q[BIT_PWR]); // R5

  AST_PWR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrbtn_evt && !en_q[BIT_PWR] && !resume_set && !sts_q[BIT_PWR]) |=> !sts_q[BIT_PWR]); // R7

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && !wdata[BIT_RESUME] && sts_q[BIT_RESUME]) |=> sts_q[BIT_RESUME]); // R5

endmodule

// File: rtl/pm_sleep_ctrl.sv
module pm_sleep_ctrl
  import pm_evt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctl,
  input  logic [15:0] wdata,
  output logic [15:0] ctl_q,
  output logic        resume_set,
  output logic        off_req,
  output logic        rst_req
);

  logic                  go;
  logic [CTL_TYPE_W-1:0] slp_type;

  assign go         = wr_ctl & wdata[CTL_GO];
  assign slp_type   = wdata[CTL_TYPE_LO +: CTL_TYPE_W];
  assign resume_set = go && (slp_type == SLP_WAKE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      off_req <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (wr_ctl) ctl_q <= wdata & ~(16'h1 << CTL_GO);
      off_req <= go && (slp_type == SLP_OFF);
      rst_req <= resume_set;
    end
  end

  AST_OFF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    off_req |-> ($past(wr_ctl) && $past(wdata[CTL_GO]) && ($past(wdata[12:10]) == 3'd0))); // R10

  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(off_req && rst_req)); // R11

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctl |=> (!off_req && !rst_req)); // R11

endmodule

// File: rtl/pm_evt_unit.sv
module pm_evt_unit
  import pm_evt_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned TMR_W     = 24,
  parameter int unsigned OVF_SHIFT = 23,
  localparam int unsigned RD_W     = (TMR_W > 16) ? TMR_W : 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  input  logic            pwrbtn_evt,
  input  logic [1:0]      reg_addr,
  input  logic            reg_wr,
  input  logic [15:0]     reg_wdata,
  output logic [RD_W-1:0] reg_rdata,
  output logic            sci,
  output logic            off_req,
  output logic            rst_req
);

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_hit;
  logic             rearm;
  logic [15:0]      sts_q;
  logic [15:0]      en_q;
  logic [15:0]      ctl_q;
  logic             resume_set;
  logic             wr_sts;
  logic             wr_en;
  logic             wr_ctl;

  assign wr_sts = reg_wr && (reg_addr == REG_STS);
  assign wr_en  = reg_wr && (reg_addr == REG_EN);
  assign wr_ctl = reg_wr && (reg_addr == REG_CTL);

  pm_tick_timer #(.CNT_W(CNT_W), .OVF_SHIFT(OVF_SHIFT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .rearm   (rearm),
    .cnt_q   (cnt_q),
    .ovf_hit (ovf_hit)
  );

  pm_status_regs u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_sts     (wr_sts),
    .wr_en      (wr_en),
    .wdata      (reg_wdata),
    .ovf_hit    (ovf_hit),
    .pwrbtn_evt (pwrbtn_evt),
    .resume_set (resume_set),
    .sts_q      (sts_q),
    .en_q       (en_q),
    .rearm      (rearm),
    .sci        (sci)
  );

  pm_sleep_ctrl u_sleep (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctl     (wr_ctl),
    .wdata      (reg_wdata),
    .ctl_q      (ctl_q),
    .resume_set (resume_set),
    .off_req    (off_req),
    .rst_req    (rst_req)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_STS: reg_rdata[15:0]      = sts_q;
      REG_EN:  reg_rdata[15:0]      = en_q;
      REG_CTL: reg_rdata[15:0]      = ctl_q;
      default: reg_rdata[TMR_W-1:0] = cnt_q[TMR_W-1:0];
    endcase
  end

  AST_RST_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (sts_q[BIT_RESUME] && sts_q[BIT_PWR])); // R11

  AST_SCI_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sci) |-> (sts_q != 16'h0)); // R8

endmodule

// File: tb/pm_evt_unit_bench.sv
module pm_evt_unit_bench;

  localparam int CW = 16;
  localparam int TW = 10;
  localparam int SH = 6;
  localparam int PER = 1 << SH;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        pwrbtn_evt = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        sci, off_req, rst_req;

  int total = 0;
  int bad = 0;

  // behavioural reference state
  int m_cnt, m_pt, m_sts, m_en, m_ctl;
  bit m_off, m_rst;

  always #5 clk = ~clk;

  pm_evt_unit #(.CNT_W(CW), .TMR_W(TW), .OVF_SHIFT(SH)) u_pm_evt_unit (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pwrbtn_evt(pwrbtn_evt),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sci(sci), .off_req(off_req), .rst_req(rst_req)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int model_read(int a);
    case (a)
      0: return m_sts;
      1: return m_en;
      2: return m_ctl;
      default: return m_cnt % (1 << TW);
    endcase
  endfunction

  function automatic string read_tag(int a);
    case (a)
      0: return "R5 status read";
      1: return "R6 enable read";
      2: return "R9 control read";
      default: return "R2 timer read";
    endcase
  endfunction

  task automatic compare_all();
    chk("R8 sci", int'(sci), int'((m_sts & m_en) != 0));
    chk("R10 off_req", int'(off_req), int'(m_off));
    chk("R11 rst_req", int'(rst_req), int'(m_rst));
    chk(read_tag(int'(reg_addr)), int'(reg_rdata), model_read(int'(reg_addr)));
  endtask

  // one clock: predict, advance, compare
  task automatic step();
    int n_sts, n_cnt, n_pt, n_en, n_ctl, typ;
    bit rearm, go, n_off, n_rst;
    rearm = reg_wr && reg_addr == 0 && reg_wdata[0] && m_sts[0];
    go    = reg_wr && reg_addr == 2 && reg_wdata[13];
    typ   = int'(reg_wdata[12:10]);
    n_sts = m_sts;
    if (reg_wr && reg_addr == 0) n_sts = n_sts & ~int'(reg_wdata);
    if (m_cnt >= m_pt && !rearm) n_sts = n_sts | 1;
    if (pwrbtn_evt && m_en[8]) n_sts = n_sts | 'h100;
    n_off = go && typ == 0;
    n_rst = go && typ == 1;
    if (n_rst) n_sts = n_sts | 'h8100;
    n_pt  = rearm ? (m_cnt / PER + 1) * PER : m_pt;
    n_cnt = m_cnt + int'(tick_en);
    n_en  = (reg_wr && reg_addr == 1) ? (int'(reg_wdata) & 'h0521) : m_en;
    n_ctl = (reg_wr && reg_addr == 2) ? (int'(reg_wdata) & 'hDFFF) : m_ctl;
    @(posedge clk);
    #1;
    m_sts = n_sts; m_cnt = n_cnt; m_pt = n_pt; m_en = n_en; m_ctl = n_ctl;
    m_off = n_off; m_rst = n_rst;
    compare_all();
  endtask

  task automatic wr_reg(int a, int d);
    reg_addr = 2'(a); reg_wdata = 16'(d); reg_wr = 1'b1;
    step();
    reg_wr = 1'b0; reg_wdata = 16'h0;
  endtask

  task automatic peek(int a, int exp, string tag);
    reg_addr = 2'(a);
    #1;
    chk(tag, int'(reg_rdata), exp);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_cnt = 0; m_pt = PER; m_sts = 0; m_en = 0; m_ctl = 0; m_off = 0; m_rst = 0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) peek(a, 0, "R1 reset read");
    chk("R1 sci at reset", int'(sci), 0);
    chk("R1 off_req at reset", int'(off_req), 0);
    chk("R1 rst_req at reset", int'(rst_req), 0);

    // R2/R3 count up to first overflow point
    reg_addr = 2'd3;
    tick_en = 1'b1;
    while (m_cnt < PER) step();
    peek(0, 0, "R3 not yet flagged on reaching point");
    step();
    peek(0, 1, "R3 flag one clock after point");
    wr_reg(3, 'hFFFF);
    peek(3, m_cnt % (1 << TW), "R2 timer write ignored");

    // R6 enable masking, R8 sci
    wr_reg(1, 'hFFFF);
    peek(1, 'h0521, "R6 enable mask");
    chk("R8 sci with pending overflow", int'(sci), 1);
    wr_reg(1, 'h0001);

    // R4 boundary: clear at count one below a period
    while (m_cnt != 2 * PER - 1) step();
    tick_en = 1'b0;
    wr_reg(0, 1);
    peek(0, 0, "R4 flag cleared");
    chk("R8 sci drops after clear", int'(sci), 0);
    tick_en = 1'b1;
    step();
    tick_en = 1'b0;
    step();
    peek(0, 1, "R4 rearm at next count");
    // R4 ordinary clear mid period
    tick_en = 1'b1;
    repeat (5) step();
    wr_reg(0, 1);
    while (m_cnt < 3 * PER) begin
      reg_addr = 2'd0; step();
    end
    step();
    peek(0, 1, "R4 next period flag");
    wr_reg(0, 1);
    wr_reg(0, 1);
    peek(0, 0, "R4 clear while idle keeps point");

    // R7 power button gating
    tick_en = 1'b0;
    pwrbtn_evt = 1'b1; step(); pwrbtn_evt = 1'b0;
    peek(0, 0, "R7 button ignored when disabled");
    wr_reg(1, 'h0100);
    pwrbtn_evt = 1'b1; step(); pwrbtn_evt = 1'b0;
    peek(0, 'h100, "R7 button sets status");
    chk("R8 sci from button", int'(sci), 1);

    // R5 write-one-to-clear details
    wr_reg(0, 'h00FF);
    peek(0, 'h100, "R5 zero bits leave status");
    reg_addr = 2'd0; reg_wdata = 16'h0100; reg_wr = 1'b1; pwrbtn_evt = 1'b1;
    step();
    reg_wr = 1'b0; pwrbtn_evt = 1'b0;
    peek(0, 'h100, "R5 set wins over clear");
    wr_reg(0, 'h0100);
    peek(0, 0, "R5 one clears bit");

    // R9 control storage, R10/R11 sleep commands
    wr_reg(2, 'h2C05);
    peek(2, 'h0C05, "R9 go bit reads zero");
    chk("R11 other type no reset", int'(rst_req), 0);
    wr_reg(2, 'h0000);
    chk("R10 no go no off", int'(off_req), 0);
    wr_reg(2, 'h2000);
    chk("R10 off pulse", int'(off_req), 1);
    step();
    chk("R10 off single cycle", int'(off_req), 0);
    wr_reg(2, 'h2400);
    chk("R11 reset pulse", int'(rst_req), 1);
    peek(0, 'h8100, "R11 resume and button status");
    step();
    chk("R11 reset single cycle", int'(rst_req), 0);

    // R2 timer readback wraps at TMR_W bits
    tick_en = 1'b1;
    reg_addr = 2'd3;
    while (m_cnt < (1 << TW) + 20) step();
    peek(3, m_cnt % (1 << TW), "R2 timer low bits");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule